// File: doc/BRIEF.md
# Handshaked SRAM Access Controller

This block puts a small state machine in front of an on-chip storage array. The array is 256 words of 8 bits by default. A requester raises a select line and gives it a direction bit, an address and write data. The controller then performs exactly one access, either a read or a write. It reports completion with a one-cycle ready pulse. When the access was a read, an output-enable flag rises in the same cycle to show that the read word is valid on the data output.

The controller captures the request when it accepts it. After that the requester may change or drop its inputs. The states are named as follows:

- ST_IDLE: waiting for a request.
- ST_READ: the array word is loaded into the output register.
- ST_WRITE: the captured data is stored.
- ST_DONE: the completion cycle.

The transitions are:

- ST_IDLE→ST_IDLE when select is low.
- ST_IDLE→ST_WRITE on select with the direction bit high.
- ST_IDLE→ST_READ on select with the direction bit low.
- ST_READ→ST_DONE and ST_WRITE→ST_DONE, always.
- ST_DONE→ST_IDLE, always.

Top module: `hs_sram_ctrl`

## Requirements
- R1: While the synchronous active-high reset is asserted, the controller returns to ST_IDLE. After the reset edge, ready is 0, out_en is 0 and rd_data is 0.
- R2: In ST_IDLE with req_sel=1, the next state is ST_WRITE if req_wr=1 and ST_READ if req_wr=0. In ST_IDLE with req_sel=0, the controller stays idle and ready stays 0.
- R3: A write stores the captured data at the captured address. out_en stays 0 for the whole write transaction.
- R4: A read loads the word at the captured address into rd_data. out_en is 1 exactly in the ST_DONE cycle of a read, the same cycle in which ready is 1.
- R5: ready is 0 in the access-state cycle. ready is 1 for exactly one cycle, two clock edges after acceptance, and is 0 again afterwards. There is one pulse per transaction.
- R6: Address, write data and direction are registered at acceptance. Changing req_addr, req_wdata or req_wr after the accepting edge has no effect on that transaction.
- R7: rd_data holds the last read value until the next read completes. Writes do not alter it. out_en falls when the controller leaves ST_DONE.
- R8: req_sel is ignored outside ST_IDLE. A request held high through ST_DONE is accepted on the first cycle back in ST_IDLE, so ready pulses at edges 2 and 5 after the first acceptance.
- R9: Reset does not clear the array. A word written before reset reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_sel | input | 1 | Request select, sampled only in ST_IDLE |
| req_wr | input | 1 | Direction: 1 write, 0 read |
| req_addr | input | AW (8) | Word address |
| req_wdata | input | DW (8) | Data to store on a write |
| rd_data | output | DW (8) | Registered read word |
| out_en | output | 1 | High in the completion cycle of a read |
| ready | output | 1 | One-cycle completion pulse |

## Verification
The bench writes a computed pattern to every address, including 0x00 and 0xFF, and reads all of them back. A decoder that drops or aliases an address bit would return the wrong word. It scrambles address, data and direction right after acceptance, which exposes a controller that uses live inputs instead of captured ones. It holds select high through ST_DONE, so a controller that accepts outside idle would produce its second ready pulse one cycle early. It also checks that a write leaves rd_data and out_en untouched, and that a reset leaves the stored words intact.

// File: rtl/hs_sram_pkg.sv
package hs_sram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } hs_state_e;
endpackage

// File: rtl/hs_sram_seq.sv
module hs_sram_seq
    import hs_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_sel,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output hs_state_e     state,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_wdata,
    output logic          cap_wr
);
    hs_state_e state_nx;
    logic      accept;

    assign accept = (state == ST_IDLE) && req_sel;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = req_sel ? (req_wr ? ST_WRITE : ST_READ) : ST_IDLE;
            ST_READ:  state_nx = ST_DONE;
            ST_WRITE: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // request capture at acceptance (R6)
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_wr    <= 1'b0;
        end else if (accept) begin
            cap_addr  <= req_addr;
            cap_wdata <= req_wdata;
            cap_wr    <= req_wr;
        end
    end
endmodule

// File: rtl/hs_sram_store.sv
module hs_sram_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rword
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // no reset on purpose: contents survive reset (R9)
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rword = cells[addr];
endmodule

// File: rtl/hs_sram_rdreg.sv
module hs_sram_rdreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/hs_sram_ctrl.sv
module hs_sram_ctrl
    import hs_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_sel,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          out_en,
    output logic          ready
);
    hs_state_e     state;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_wdata;
    logic          cap_wr;
    logic [DW-1:0] arr_word;

    hs_sram_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_sel   (req_sel),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .state     (state),
        .cap_addr  (cap_addr),
        .cap_wdata (cap_wdata),
        .cap_wr    (cap_wr)
    );

    hs_sram_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .we    (state == ST_WRITE),
        .addr  (cap_addr),
        .wdata (cap_wdata),
        .rword (arr_word)
    );

    hs_sram_rdreg #(.DW(DW)) u_rdreg (
        .clk  (clk),
        .rst  (rst),
        .load (state == ST_READ),
        .din  (arr_word),
        .dout (rd_data)
    );

    // handshake outputs decoded from the state register
    always_comb begin
        ready  = (state == ST_DONE);
        out_en = (state == ST_DONE) && !cap_wr;
    end
endmodule

// File: rtl/hs_sram_ctrl_chk.sv
module hs_sram_ctrl_chk
    import hs_sram_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          req_sel,
    input logic          req_wr,
    input hs_state_e     state,
    input logic          ready,
    input logic          out_en,
    input logic [DW-1:0] rd_data
);
    a_r1_reset_outputs: assert property (@(posedge clk)
        rst |=> (!ready && !out_en && rd_data == '0));

    a_r2_accept_write: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_sel && req_wr) |=> state == ST_WRITE);

    a_r2_accept_read: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_sel && !req_wr) |=> state == ST_READ);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !req_sel) |=> state == ST_IDLE);

    a_r5_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    a_r5_ready_after_access: assert property (@(posedge clk) disable iff (rst)
        ready |-> ($past(state) == ST_READ || $past(state) == ST_WRITE));

    a_r4_oe_read_done: assert property (@(posedge clk) disable iff (rst)
        out_en |-> (ready && $past(state) == ST_READ));

    a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(rd_data)) |-> out_en);

    a_r8_done_ignores_sel: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> state == ST_IDLE);
endmodule

bind hs_sram_ctrl hs_sram_ctrl_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_sel (req_sel),
    .req_wr  (req_wr),
    .state   (state),
    .ready   (ready),
    .out_en  (out_en),
    .rd_data (rd_data)
);

// File: tb/test_hs_sram_ctrl.sv
`timescale 1ns/1ps
module test_hs_sram_ctrl;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_sel = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          out_en;
    logic          ready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    hs_sram_ctrl #(.AW(AW), .DW(DW)) i_hs_sram_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_sel   (req_sel),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .out_en    (out_en),
        .ready     (ready)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a * 73 + 29 + salt * 101) ^ (a >> 3));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one transaction; inputs scrambled after acceptance (R6)
    task automatic txn(input logic wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] got);
        @(negedge clk);
        req_sel = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_sel = 1'b0; req_wr = ~wr; req_addr = ~a; req_wdata = ~d;
        check(ready == 1'b0, "R5 ready low in access cycle", int'(ready), 0);
        check(out_en == 1'b0, "R3/R4 out_en low in access cycle", int'(out_en), 0);
        @(negedge clk);
        check(ready == 1'b1, "R5 ready in done cycle", int'(ready), 1);
        check(out_en == !wr, "R4 out_en follows direction", int'(out_en), int'(!wr));
        got = rd_data;
        @(negedge clk);
        check(ready == 1'b0, "R5 ready single pulse", int'(ready), 0);
        check(out_en == 1'b0, "R7 out_en falls after done", int'(out_en), 0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        logic [DW-1:0] got;
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ready == 0, "R1 ready after reset", int'(ready), 0);
        check(out_en == 0, "R1 out_en after reset", int'(out_en), 0);
        check(rd_data == 0, "R1 rd_data after reset", int'(rd_data), 0);
        rst = 1'b0;

        // R2 idle without select
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(ready == 0, "R2 idle stays idle", int'(ready), 0);
        end

        // R3 sweep writes, every address incl. 0x00 and 0xFF
        for (int a = 0; a < N; a++) begin
            txn(1'b1, AW'(a), pat(a, 0), got);
            check(rd_data == 0, "R7 write leaves rd_data", int'(rd_data), 0);
        end
        // R4 read back every address
        for (int a = 0; a < N; a++) begin
            txn(1'b0, AW'(a), 8'h00, got);
            check(got == pat(a, 0), "R4 read word", int'(got), int'(pat(a, 0)));
        end

        // R7 rd_data held across a write
        txn(1'b0, 8'hFF, 8'h00, got);
        held = got;
        txn(1'b1, 8'h10, 8'h3C, got);
        check(rd_data == held, "R7 rd_data held over write", int'(rd_data), int'(held));
        txn(1'b0, 8'h10, 8'h00, got);
        check(got == 8'h3C, "R6 captured write data", int'(got), 8'h3C);
        check(rd_data == 8'h3C, "R7 rd_data updated by read", int'(rd_data), 8'h3C);

        // R8 request held through done: pulses after edges 2 and 5
        @(negedge clk);
        req_sel = 1'b1; req_wr = 1'b0; req_addr = 8'h00;
        @(negedge clk); check(ready == 0, "R8 edge1", int'(ready), 0);
        @(negedge clk); check(ready == 1, "R8 edge2", int'(ready), 1);
        check(rd_data == pat(0, 0), "R8 first read", int'(rd_data), int'(pat(0, 0)));
        req_addr = 8'hFF;
        @(negedge clk); check(ready == 0, "R8 edge3 sel ignored in done", int'(ready), 0);
        @(negedge clk); check(ready == 0, "R8 edge4 re-accepted", int'(ready), 0);
        req_sel = 1'b0;
        @(negedge clk); check(ready == 1, "R8 edge5 second pulse", int'(ready), 1);
        check(rd_data == pat(255, 0), "R8 second read", int'(rd_data), int'(pat(255, 0)));
        @(negedge clk); check(ready == 0, "R8 after second pulse", int'(ready), 0);

        // R9 array survives reset
        txn(1'b1, 8'h00, 8'hA5, got);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(rd_data == 0, "R1 rd_data cleared by reset", int'(rd_data), 0);
        rst = 1'b0;
        txn(1'b0, 8'h00, 8'h00, got);
        check(got == 8'hA5, "R9 array kept across reset", int'(got), 8'hA5);
        txn(1'b0, 8'h80, 8'h00, got);
        check(got == pat(128, 0), "R9 other word kept", int'(got), int'(pat(128, 0)));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule